// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave end of a two-wire serial memory holding 128 bytes. It oversamples the clock line and the data line with the system clock. It recognises start and stop conditions and checks the device-select field of each control byte. It answers on the data line by pulling it low through an output-enable, as an open-drain driver would. A single 7-bit word pointer serves both reads and writes, and it advances after every byte that is stored or sent.

A master sets the pointer with a write header followed by an address byte. It can then store one byte, or issue a repeated start and a read header to read from that address. A read header with no address byte reads from wherever the pointer stands, which is one past the last byte accessed. After each byte read, the master acknowledges to get the next byte or declines to end the read. The pointer wraps from the top of the array to zero.

Top module: `twowire_rdmem_slave`

## Requirements
- R1: After reset, and after any stop condition (data line rising while the clock line is high), the slave releases the data line. A start condition (data line falling while the clock line is high) begins a new transaction from any state.
- R2: The first byte after a start is taken MSB first: bits 7..1 are the device select and bit 0 is the read flag (1 = read). On a device-select match the slave pulls the data line low during the ninth clock. On a mismatch it gives no acknowledge and leaves the data line released until the next start.
- R3: After a write header, the next byte loads the pointer from its low 7 bits; bit 7 is ignored. The slave acknowledges this byte.
- R4: A byte that follows the address byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R5: After a read header is acknowledged, the slave sends the byte at the pointer MSB first, one bit per clock, and the pointer advances by one.
- R6: A read header with no address byte returns the byte one past the last one accessed, whether that access was a read or a write.
- R7: A repeated start right after an acknowledged address byte ends the write but keeps the loaded pointer, so the next read header reads that address.
- R8: When the master acknowledges a data byte (data line low in the ninth clock), the next byte in address order follows, and address 127 is followed by address 0.
- R9: When the master does not acknowledge a data byte, the slave stops sending and keeps the data line released until the next start. The pointer remains one past the last byte sent.
- R10: The slave changes its drive on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume a well-formed bus. Each clock-line phase lasts several system clocks, so that every edge survives the two-flop synchronizer as its own event. The master changes the data line only while the clock line is low, except when it makes a start or a stop. It never makes a start or stop while the slave is pulling the line low. The bench master works in quarter-bit steps of four system clocks. It always lets the slave release the line before it makes a start or stop, so the stimulus stays within these assumptions.

// File: rtl/twowire_rdmem_slave.sv
module twowire_rdmem_slave #(
  parameter int         AW     = 7,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] PTR_ONE = 1;

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_CTRL = 3'd1, S_ADDR = 3'd2,
                            S_WDATA = 3'd3, S_READ = 3'd4} st_t;

  st_t           state;
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    sr, tx;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [DEPTH];

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] rd_byte = mem[ptr];
  wire wr_en     = scl_fall && (cnt == 4'd8) && (state == S_WDATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      state <= S_CTRL; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (cnt == 4'd8) begin
          cnt <= '0;
          if (state == S_CTRL)
            state <= sr[0] ? S_READ : S_ADDR;
          else if (state == S_READ) begin
            if (sda_s) state <= S_IDLE;
            else begin
              tx  <= rd_byte;
              ptr <= ptr + PTR_ONE;
            end
          end
        end else begin
          cnt <= cnt + 4'd1;
          sr  <= {sr[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (state == S_READ)
          sda_oe <= (cnt < 4'd8) ? ~tx[3'd7 - cnt[2:0]] : 1'b0;
        else if (cnt == 4'd8) begin
          case (state)
            S_CTRL:
              if (sr[7:1] == DEV_ID) begin
                sda_oe <= 1'b1;
                if (sr[0]) begin
                  tx  <= rd_byte;
                  ptr <= ptr + PTR_ONE;
                end
              end else state <= S_IDLE;
            S_ADDR: begin
              ptr    <= sr[AW-1:0];
              sda_oe <= 1'b1;
              state  <= S_WDATA;
            end
            S_WDATA: begin
              ptr    <= ptr + PTR_ONE;
              sda_oe <= 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else
          sda_oe <= 1'b0;
      end
    end
endmodule

// File: rtl/twowire_rdmem_chk.sv
module twowire_rdmem_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic [2:0]    state,
  input logic [3:0]    cnt,
  input logic [AW-1:0] ptr
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);  // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);  // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && $past(state) != 3'd2) |-> ptr == AW'($past(ptr) + 1'b1));  // R8
  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(state) != 3'd4) |-> $past(cnt) == 4'd8);  // R2
endmodule

bind twowire_rdmem_slave twowire_rdmem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .state(state), .cnt(cnt), .ptr(ptr));

// File: tb/twowire_rdmem_slave_bench.sv
module twowire_rdmem_slave_bench;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  int   tests = 0, fails = 0, r10_bad = 0;
  logic [7:0] model [128];
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  twowire_rdmem_slave u_twowire_rdmem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe));

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) r10_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    wt(Q); m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); s = sda_line; wt(Q); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(!m_ack, s);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic cur_read(output logic [7:0] d, output logic ack);
    bus_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b0, d); bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start(); send_byte({DEV, 1'b0}, k1); send_byte(a, k2);
    bus_start(); send_byte({DEV, 1'b1}, k3); recv_byte(1'b0, d); bus_stop();
    ok = k1 & k2 & k3;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a1, a2, a3, s, allhi;
    logic [7:0] d;
    logic [7:0] raddr [5];
    raddr[0] = 8'h85; raddr[1] = 8'h00; raddr[2] = 8'h40; raddr[3] = 8'h7F; raddr[4] = 8'h63;

    wt(5);
    chk(sda_oe == 1'b0, "R1 reset release", int'(sda_oe), 0);
    rst_n = 1'b1;
    wt(5);

    bus_start();
    send_byte({7'h51, 1'b0}, a1);
    chk(!a1, "R2 mismatch no ack", int'(a1), 0);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R2 ignored until start", int'(d), 8'hFF);
    bus_stop();

    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({DEV, 1'b0}, a1); send_byte(8'(a), a2); send_byte(pat(a), a3);
      bus_stop();
      model[a] = pat(a);
      chk(a1 & a2 & a3, "R3 R4 write acks", int'({a1, a2, a3}), 7);
    end
    chk(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);

    cur_read(d, a1);
    chk(a1, "R5 read header ack", int'(a1), 1);
    chk(d == model[0], "R6 current after write 127 wraps", int'(d), int'(model[0]));
    cur_read(d, a1);
    chk(d == model[1], "R6 current after read", int'(d), int'(model[1]));

    for (int i = 0; i < 5; i++) begin
      rand_read(raddr[i], d, a1);
      chk(a1 && d == model[raddr[i][6:0]], "R7 random read (R3 bit7 ignored)",
          int'(d), int'(model[raddr[i][6:0]]));
    end

    bus_start();
    send_byte({DEV, 1'b0}, a1); send_byte(8'd50, a2); send_byte(8'hA5, a3);
    bus_stop();
    model[50] = 8'hA5;
    cur_read(d, a1);
    chk(d == model[51], "R6 current after write 50", int'(d), int'(model[51]));
    rand_read(8'd50, d, a1);
    chk(d == 8'hA5, "R4 rewritten byte", int'(d), 8'hA5);

    bus_start();
    send_byte({DEV, 1'b0}, a1); send_byte(8'd120, a2);
    bus_start(); send_byte({DEV, 1'b1}, a3);
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, d);
      chk(d == model[(120 + i) % 128], "R8 sequential wrap", int'(d), int'(model[(120 + i) % 128]));
    end
    allhi = 1'b1;
    for (int i = 0; i < 9; i++) begin bit_io(1'b1, s); allhi &= s; end
    chk(allhi, "R9 released after nack", int'(allhi), 1);
    bus_stop();
    cur_read(d, a1);
    chk(d == model[8], "R9 pointer after nack", int'(d), int'(model[8]));

    bus_start();
    send_byte({DEV, 1'b0}, a1); send_byte(8'd0, a2);
    bus_start(); send_byte({DEV, 1'b1}, a3);
    for (int i = 0; i < 130; i++) begin
      recv_byte(i != 129, d);
      chk(d == model[i % 128], "R8 full array read", int'(d), int'(model[i % 128]));
    end
    bus_stop();

    chk(r10_bad == 0, "R10 drive changes with clock low", r10_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule